// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block turns the three-level line symbols of a 100 Mb/s twisted-pair receiver into receive nibbles. The symbols arrive already sliced and already timed by a recovered bit clock. For each symbol it finds the two-level NRZI bit from the level changes, and then the NRZ bit from the NRZI transitions. An additive descrambler strips the key stream that the far end added. The descrambler brings its key register into step by treating the idle stream as known plaintext. It declares lock once enough consecutive descrambled ones have been seen. It drops lock when no idle run has arrived for a long stretch of bit time.

Once locked, the block hunts for the start-of-stream delimiter pair. That pair fixes the 5-bit code-group boundaries. Each following code group is translated to a data nibble and presented with a one-cycle strobe, until an end delimiter, an idle group or loss of lock closes the frame.

The symbol input is valid-only: the line cannot be stalled, so there is no ready and every cycle with `sym_valid` high consumes one symbol. The output side has no back-pressure either. A consumer must take `rxd`/`rx_dv`/`rx_er` in the cycle that `nib_stb` is high. These outputs hold their values until the next strobe.

Top module: `fe_rx_decode`

## Requirements
- R1: A symbol is consumed only in a cycle with `sym_valid` high. Level codes are 2'b00 zero, 2'b01 positive and 2'b10 negative. Cycles with `sym_valid` low have no effect, whatever `sym_lvl` carries.
- R2: The NRZI bit is one when the level differs from the previous consumed symbol, and zero otherwise. The NRZ bit is the XOR of consecutive NRZI bits. The result does not depend on the sign convention of the non-zero levels.
- R3: The descrambler removes an additive key stream. The key bit is k[n] = k[n-11] XOR k[n-9]. `locked` rises after LOCK_ONES consecutive descrambled ones, and it is low for fewer than LOCK_ONES.
- R4: While locked, if HOLD_BITS consumed bits pass without a run of IDLE_RUN consecutive descrambled ones, `locked` falls.
- R5: Framing starts where the bit pair 11000 then 10001 is seen, in that order, first-received bit leftmost. The delimiter itself produces no strobe. `rx_dv` rises with the strobe of the first data group after it.
- R6: Data groups map to nibbles as follows: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. Each is strobed with `rx_dv`=1 and `rx_er`=0.
- R7: Any other group inside a frame (except 01101 and 11111) is strobed with `rx_dv`=1, `rx_er`=1 and `rxd`=0.
- R8: The end group 01101 closes the frame with a strobe carrying `rx_dv`=0, `rx_er`=0 and `rxd`=0.
- R9: An idle group 11111 inside a frame, or loss of lock inside a frame, closes it with a strobe carrying `rx_dv`=0, `rx_er`=1 and `rxd`=0.
- R10: While not locked, `rx_dv` is low, delimiters are ignored and no strobe is produced.
- R11: `rxd`, `rx_dv` and `rx_er` change only in a cycle where `nib_stb` is high.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A line symbol is present this cycle |
| sym_lvl | input | 2 | Line level: 00 zero, 01 positive, 10 negative |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Nibble belongs to a frame |
| rx_er | output | 1 | Coding error or aborted frame |
| nib_stb | output | 1 | One-cycle strobe: new rxd/rx_dv/rx_er |
| locked | output | 1 | Descrambler is in step with the far end |

## Verification
A key register out of step with the far end shows at the ports as `locked` never rising, because idle no longer descrambles to ones. If the key goes wrong while locked, valid frames start coming out with `rx_er` set from their first nibble. A wrong group boundary or counter gives the wrong nibbles within five bits after the delimiter, or gives no strobe at all. A stuck lock timer shows as `locked` outliving an idle-free stretch by more than HOLD_BITS bits. A wrong line-stage memory corrupts the first descrambled bits after a polarity change and delays lock.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

  localparam int KEY_W  = 11;
  localparam int TAP_HI = 10;
  localparam int TAP_LO = 8;
  localparam int GROUP_W = 5;
  localparam int NIB_W   = 4;

  localparam logic [2*GROUP_W-1:0] SSD_PAIR = 10'b11000_10001;

  typedef enum logic [1:0] {CG_DATA, CG_END, CG_IDLE, CG_BAD} cg_kind_e;

  typedef struct packed {
    cg_kind_e          kind;
    logic [NIB_W-1:0]  nib;
  } cg_info_t;

  function automatic cg_info_t decode_cg(input logic [GROUP_W-1:0] cg);
    cg_info_t r;
    r.kind = CG_DATA;
    r.nib  = '0;
    case (cg)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      5'b01101: r.kind = CG_END;
      5'b11111: r.kind = CG_IDLE;
      default:  r.kind = CG_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fe_line_decode.sv
module fe_line_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_lvl,
  output logic       nrz_bit,
  output logic       nrz_valid
);
  logic [1:0] lvl_q;
  logic       nrzi_q;
  logic       nrzi_now;

  // R2: a level change is an NRZI one; an NRZI transition is an NRZ one
  assign nrzi_now = (sym_lvl != lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= 2'b00;
      nrzi_q    <= 1'b0;
      nrz_bit   <= 1'b0;
      nrz_valid <= 1'b0;
    end else begin
      nrz_valid <= sym_valid;
      if (sym_valid) begin
        lvl_q   <= sym_lvl;
        nrzi_q  <= nrzi_now;
        nrz_bit <= nrzi_now ^ nrzi_q;
      end
    end
  end
endmodule

// File: rtl/fe_descrambler.sv
module fe_descrambler #(
  parameter int LOCK_ONES = 60,
  parameter int HOLD_BITS = 90250,
  parameter int IDLE_RUN  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_valid,
  output logic out_bit,
  output logic out_valid,
  output logic lock
);
  import fe_rx_pkg::*;

  localparam int OW = $clog2(LOCK_ONES + 1);
  localparam int TW = $clog2(HOLD_BITS + 1);
  localparam int RW = $clog2(IDLE_RUN + 1);
  localparam logic [OW-1:0] ONES_LAST  = OW'(LOCK_ONES - 1);
  localparam logic [TW-1:0] QUIET_LAST = TW'(HOLD_BITS - 1);
  localparam logic [RW-1:0] RUN_FULL   = RW'(IDLE_RUN);

  logic [KEY_W-1:0] key_q;
  logic             key_bit;
  logic             plain;
  logic [OW-1:0]    ones_q;
  logic [TW-1:0]    quiet_q;
  logic [RW-1:0]    run_q;
  logic [RW-1:0]    run_nx;

  assign key_bit = key_q[TAP_HI] ^ key_q[TAP_LO];
  assign plain   = in_bit ^ key_bit;

  always_comb begin
    if (!plain)               run_nx = '0;
    else if (run_q == RUN_FULL) run_nx = run_q;
    else                      run_nx = run_q + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q     <= '0;
      ones_q    <= '0;
      quiet_q   <= '0;
      run_q     <= '0;
      lock      <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bit <= plain;
        run_q   <= run_nx;
        // R3: unlocked, idle is assumed, so the inverted line bit is the key
        key_q   <= {key_q[KEY_W-2:0], lock ? key_bit : ~in_bit};
        if (!lock) begin
          quiet_q <= '0;
          if (!plain) begin
            ones_q <= '0;
          end else if (ones_q == ONES_LAST) begin
            lock   <= 1'b1;
            ones_q <= '0;
          end else begin
            ones_q <= ones_q + OW'(1);
          end
        end else begin
          // R4: watch for idle runs while locked
          if (run_nx == RUN_FULL) begin
            quiet_q <= '0;
          end else if (quiet_q == QUIET_LAST) begin
            lock    <= 1'b0;
            quiet_q <= '0;
          end else begin
            quiet_q <= quiet_q + TW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/fe_group_align.sv
module fe_group_align (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_valid,
  input  logic       lock_in,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       nib_stb,
  output logic       locked
);
  import fe_rx_pkg::*;

  localparam int CW = $clog2(GROUP_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(GROUP_W - 1);

  logic [2*GROUP_W-1:0] sh_q;
  logic [2*GROUP_W-1:0] sh_n;
  logic                 in_frame;
  logic [CW-1:0]        cnt_q;
  cg_info_t             info;

  assign sh_n = {sh_q[2*GROUP_W-2:0], bit_in};
  assign info = decode_cg(sh_n[GROUP_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      in_frame <= 1'b0;
      cnt_q    <= '0;
      rxd      <= '0;
      rx_dv    <= 1'b0;
      rx_er    <= 1'b0;
      nib_stb  <= 1'b0;
      locked   <= 1'b0;
    end else begin
      nib_stb <= 1'b0;
      locked  <= lock_in;
      if (bit_valid) sh_q <= sh_n;
      if (!lock_in) begin
        // R9/R10: lock lost closes any open frame
        if (in_frame) begin
          nib_stb <= 1'b1;
          rx_dv   <= 1'b0;
          rx_er   <= 1'b1;
          rxd     <= '0;
        end
        in_frame <= 1'b0;
      end else if (bit_valid) begin
        if (!in_frame) begin
          if (sh_n == SSD_PAIR) begin   // R5
            in_frame <= 1'b1;
            cnt_q    <= '0;
          end
        end else if (cnt_q == CNT_LAST) begin
          cnt_q   <= '0;
          nib_stb <= 1'b1;
          case (info.kind)
            CG_DATA: begin rx_dv <= 1'b1; rx_er <= 1'b0; rxd <= info.nib; end
            CG_BAD:  begin rx_dv <= 1'b1; rx_er <= 1'b1; rxd <= '0; end
            CG_END:  begin rx_dv <= 1'b0; rx_er <= 1'b0; rxd <= '0; in_frame <= 1'b0; end
            default: begin rx_dv <= 1'b0; rx_er <= 1'b1; rxd <= '0; in_frame <= 1'b0; end
          endcase
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fe_rx_decode.sv
module fe_rx_decode #(
  parameter int LOCK_ONES = 60,
  parameter int HOLD_BITS = 90250,
  parameter int IDLE_RUN  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_lvl,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       nib_stb,
  output logic       locked
);
  logic nrz_bit, nrz_valid;
  logic plain_bit, plain_valid, key_lock;

  fe_line_decode u_line (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_lvl(sym_lvl),
    .nrz_bit(nrz_bit), .nrz_valid(nrz_valid)
  );

  fe_descrambler #(
    .LOCK_ONES(LOCK_ONES), .HOLD_BITS(HOLD_BITS), .IDLE_RUN(IDLE_RUN)
  ) u_dscr (
    .clk(clk), .rst_n(rst_n), .in_bit(nrz_bit), .in_valid(nrz_valid),
    .out_bit(plain_bit), .out_valid(plain_valid), .lock(key_lock)
  );

  fe_group_align u_align (
    .clk(clk), .rst_n(rst_n), .bit_in(plain_bit), .bit_valid(plain_valid),
    .lock_in(key_lock), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .nib_stb(nib_stb), .locked(locked)
  );
endmodule

// File: rtl/fe_rx_decode_chk.sv
module fe_rx_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       nib_stb,
  input logic       locked
);
  assert_dv_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> locked);

  assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_stb |-> ($stable(rxd) && $stable(rx_dv) && $stable(rx_er)));

  assert_bad_group_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && rx_er) |-> (rxd == 4'h0));

  assert_fresh_lock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (!rx_dv && !nib_stb));

  assert_close_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && !rx_dv) |-> (rxd == 4'h0));
endmodule

bind fe_rx_decode fe_rx_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
  .nib_stb(nib_stb), .locked(locked)
);

// File: tb/fe_rx_decode_test.sv
module fe_rx_decode_test;
  localparam int HOLD = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym_lvl = 2'b00;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, nib_stb, locked;

  fe_rx_decode #(.LOCK_ONES(60), .HOLD_BITS(HOLD), .IDLE_RUN(10)) uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_lvl(sym_lvl),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .nib_stb(nib_stb), .locked(locked)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  logic [10:0] tx_key = 11'h5A3;
  bit          tx_nrzi = 1'b0;
  int          lvl_idx = 0;
  bit          flip = 1'b0;
  int          bit_no = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [1:0] lvl_code(input int idx);
    case (idx)
      1: return flip ? 2'b10 : 2'b01;
      3: return flip ? 2'b01 : 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  // transmitter model: scramble, NRZ->NRZI, NRZI->three-level
  task automatic send_bit(input bit p);
    bit k, c;
    k = tx_key[10] ^ tx_key[8];
    tx_key = {tx_key[9:0], k};
    c = p ^ k;
    tx_nrzi = tx_nrzi ^ c;
    if (tx_nrzi) lvl_idx = (lvl_idx + 1) % 4;
    sym_valid = 1'b1;
    sym_lvl = lvl_code(lvl_idx);
    @(posedge clk); #1;
    sym_valid = 1'b0;
    sym_lvl = (bit_no % 2 == 0) ? 2'b11 : ~lvl_code(lvl_idx);   // R1 junk while invalid
    bit_no++;
    if (bit_no % 5 == 0) begin @(posedge clk); #1; end
  endtask

  task automatic send_cg(input logic [4:0] cg);
    for (int i = 4; i >= 0; i--) send_bit(cg[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic push_exp(input bit dv, input bit er, input logic [3:0] d, input string tag);
    exp_q.push_back({dv, er, d});
    tag_q.push_back(tag);
  endtask

  task automatic send_frame(input int n, input int seed, input string tag);
    send_cg(5'b11000); send_cg(5'b10001);
    for (int k = 0; k < n; k++) begin
      logic [3:0] d;
      d = 4'((seed + 7 * k) % 16);
      push_exp(1'b1, 1'b0, d, tag);
      send_cg(enc(d));
    end
    push_exp(1'b0, 1'b0, 4'h0, "R8");
    send_cg(5'b01101); send_cg(5'b00111);
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && nib_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected strobe dv/er/rxd", int'({rx_dv, rx_er, rxd}), -1);
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rx_dv, rx_er, rxd} == e, t, "nibble dv/er/rxd", int'({rx_dv, rx_er, rxd}), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(rxd == 0 && !rx_dv && !rx_er && !nib_stb, "R12", "outputs in reset", int'({rx_dv, rx_er, nib_stb, rxd}), 0);
    chk(!locked, "R12", "locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!locked && !rx_dv, "R12", "after release", int'({locked, rx_dv}), 0);

    send_idle(25);
    settle();
    chk(!locked, "R3", "locked after too few ones", int'(locked), 0);

    // R10: delimiter and data before lock are ignored
    send_cg(5'b11000); send_cg(5'b10001);
    send_cg(enc(4'h3)); send_cg(enc(4'h7)); send_cg(5'b01101); send_cg(5'b00111);
    settle();
    chk(!rx_dv && !locked, "R10", "dv/locked before lock", int'({rx_dv, locked}), 0);

    send_idle(150);
    settle();
    chk(locked, "R3", "locked after idle", int'(locked), 1);

    send_frame(16, 0, "R6");
    send_idle(30);

    // R5: delimiter alone gives no strobe and no dv
    send_cg(5'b11000); send_cg(5'b10001);
    settle();
    chk(!rx_dv && exp_q.size() == 0, "R5", "after delimiter only", int'(rx_dv), 0);
    push_exp(1'b1, 1'b0, 4'h5, "R5"); send_cg(enc(4'h5));
    push_exp(1'b1, 1'b0, 4'hA, "R6"); send_cg(enc(4'hA));
    push_exp(1'b0, 1'b0, 4'h0, "R8"); send_cg(5'b01101); send_cg(5'b00111);
    send_idle(30);

    // R7: invalid group inside a frame
    send_cg(5'b11000); send_cg(5'b10001);
    push_exp(1'b1, 1'b0, 4'h3, "R6"); send_cg(enc(4'h3));
    push_exp(1'b1, 1'b1, 4'h0, "R7"); send_cg(5'b00000);
    push_exp(1'b1, 1'b0, 4'h9, "R6"); send_cg(enc(4'h9));
    push_exp(1'b0, 1'b0, 4'h0, "R8"); send_cg(5'b01101); send_cg(5'b00111);
    send_idle(30);

    // R9: idle inside a frame aborts it
    send_cg(5'b11000); send_cg(5'b10001);
    push_exp(1'b1, 1'b0, 4'h1, "R6"); send_cg(enc(4'h1));
    push_exp(1'b1, 1'b0, 4'h2, "R6"); send_cg(enc(4'h2));
    push_exp(1'b0, 1'b1, 4'h0, "R9"); send_cg(5'b11111);
    send_idle(30);
    settle();
    chk(!rx_dv && rx_er, "R9", "state after idle abort", int'({rx_dv, rx_er}), 1);

    // R2: opposite sign convention decodes the same
    while (lvl_idx % 2 != 0) send_bit(1'b1);
    flip = 1'b1;
    send_idle(20);
    send_frame(10, 5, "R2");
    send_idle(20);
    while (lvl_idx % 2 != 0) send_bit(1'b1);
    flip = 1'b0;
    send_idle(30);
    settle();
    chk(exp_q.size() == 0, "R11", "pending expected items", exp_q.size(), 0);
    chk(locked, "R1", "lock kept with junk in gaps", int'(locked), 1);

    // R4: idle-free stretch drops lock
    for (int i = 0; i < (HOLD - 40) / 5; i++) send_cg(5'b11110);
    settle();
    chk(locked, "R4", "locked before hold limit", int'(locked), 1);
    for (int i = 0; i < 16; i++) send_cg(5'b11110);
    settle();
    chk(!locked, "R4", "locked after hold limit", int'(locked), 0);

    send_cg(5'b11000); send_cg(5'b10001);
    send_cg(enc(4'h6)); send_cg(5'b01101); send_cg(5'b00111);
    settle();
    chk(!rx_dv, "R10", "dv after lock loss", int'(rx_dv), 0);

    send_idle(150);
    settle();
    chk(locked, "R3", "relock", int'(locked), 1);
    send_frame(4, 11, "R3");
    send_idle(20);
    settle();
    chk(exp_q.size() == 0, "R11", "final pending items", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule